// File: doc/BRIEF.md
# Reference and Converter Power Mode Controller

This block turns the two power-mode bits carried by each converter command into two enables: one for the internal voltage reference and one for the conversion core. The bus logic that decodes commands gives it a one-cycle strobe for each command, with the two mode bits alongside. It also gives a strobe for every STOP and every repeated START seen on the bus. The conversion sequencer reports the start and the end of each conversion.

Turning the reference off takes effect at once. Turning it on does not: the block holds the request until the bus boundary that closes the command. Only then does it enable the reference and load a settling counter from a runtime value. The ready flag stays low until that counter has run out. The core enable follows the mode bit directly when the mode keeps the core powered. Otherwise it is raised only while a conversion is in flight.

All pins are plain control strobes and levels. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `vref_power_ctrl`

## Requirements
- R1: After reset, the reference enable, core enable and ready flag are all low.
- R2: A command whose reference bit (cmd_mode[1]) is 1, received while the reference is off, leaves ref_en low. ref_en rises in the cycle after the next STOP or repeated-START strobe.
- R3: A command whose reference bit is 0 drives ref_en low in the next cycle. It also cancels any turn-on still waiting for a boundary, so a later boundary leaves ref_en low.
- R4: A command whose reference bit is 1, received while the reference is on, keeps ref_en high and does not drop ref_ready.
- R5: ref_ready is high only while ref_en is high. After a turn-on it rises exactly N cycles after ref_en rises, where N is settle_cycles sampled in the boundary cycle. With N = 0 it rises together with ref_en.
- R6: When the reference goes off and then on again before the settling interval has ended, the new turn-on waits the full interval again.
- R7: A command whose core bit (cmd_mode[0]) is 1 (modes 01 and 11) drives adc_en high from the next cycle, whether or not a conversion is running.
- R8: While the core bit last received is 0 (modes 00 and 10), adc_en is high from the cycle after conv_start up to and including the cycle in which conv_done is strobed, and low at all other times.
- R9: A command strobed in the same cycle as a boundary strobe is applied after that boundary. A pending turn-on is committed first, then overridden by a reference bit of 0. A reference bit of 1 with no pending turn-on waits for the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: a command byte was accepted |
| cmd_mode | input | 2 | Mode bits of that command: [1] reference, [0] core |
| bus_stop | input | 1 | One-cycle strobe: STOP seen on the bus |
| bus_rstart | input | 1 | One-cycle strobe: repeated START seen on the bus |
| settle_cycles | input | CNT_W | Settling length in cycles, sampled at each turn-on |
| conv_start | input | 1 | One-cycle strobe: a conversion begins |
| conv_done | input | 1 | One-cycle strobe: the conversion has finished |
| ref_en | output | 1 | Internal reference enable |
| adc_en | output | 1 | Conversion core enable |
| ref_ready | output | 1 | Reference enabled and settled |

## Verification
The reference path is driven with a set of command orderings. One ordering has a turn-on command followed by idle cycles and only then a STOP, which separates deferred turn-on from immediate turn-on. Another has a turn-on followed by a cancelling command before the boundary. Others repeat a turn-on command while the reference is already on, and switch off and back on in the middle of the settling interval, which shows whether the counter restarts or carries on. Commands placed in the same cycle as a boundary fix the ordering rule. The core path runs conversions with the core bit clear and then set, which tells the conversion-gated enable apart from the mode-held enable. A zero and a non-zero settle length pin down the exact cycle in which ready rises.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic [1:0] {
    PM_SLEEP    = 2'b00,
    PM_CORE     = 2'b01,
    PM_REF      = 2'b10,
    PM_BOTH     = 2'b11
  } pwr_mode_e;

  localparam int REF_BIT  = 1;
  localparam int CORE_BIT = 0;

  function automatic logic wants_ref(input logic [1:0] m);
    return m[REF_BIT];
  endfunction

  function automatic logic wants_core(input logic [1:0] m);
    return m[CORE_BIT];
  endfunction
endpackage

// File: rtl/vpc_ref_commit.sv
module vpc_ref_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid_i,
  input  logic ref_bit_i,
  input  logic boundary_i,
  output logic ref_en_o,
  output logic turn_on_o
);
  logic ref_q, pend_q;
  logic ref_d, pend_d;
  logic commit;

  // Boundary is applied first, then any command in the same cycle.
  always_comb begin
    commit = boundary_i & pend_q;
    ref_d  = ref_q | commit;
    pend_d = pend_q & ~commit;
    if (cmd_valid_i) begin
      if (!ref_bit_i) begin
        ref_d  = 1'b0;
        pend_d = 1'b0;
      end else if (!ref_d) begin
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      pend_q <= pend_d;
    end
  end

  assign ref_en_o  = ref_q;
  assign turn_on_o = ~ref_q & ref_d;

  AST_NO_EARLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_q && !boundary_i) |=> !ref_q); // R2
  AST_OFF_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && !ref_bit_i) |=> (!ref_q && !pend_q)); // R3
  AST_KEEP_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q && cmd_valid_i && ref_bit_i) |=> ref_q); // R4
endmodule

// File: rtl/vpc_settle_timer.sv
module vpc_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && cnt_q != ZERO) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready_o = run_i && (cnt_q == ZERO);

  AST_LOAD_HOLDS_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i != ZERO) |=> !ready_o); // R5
  AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
endmodule

// File: rtl/vpc_core_gate.sv
module vpc_core_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid_i,
  input  logic core_bit_i,
  input  logic conv_start_i,
  input  logic conv_done_i,
  output logic adc_en_o
);
  logic hold_q, busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (cmd_valid_i) hold_q <= core_bit_i;
      if (conv_start_i)     busy_q <= 1'b1;
      else if (conv_done_i) busy_q <= 1'b0;
    end
  end

  assign adc_en_o = hold_q | busy_q;

  AST_MODE_HOLDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && core_bit_i) |=> adc_en_o); // R7
  AST_IDLE_CORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_i && !conv_start_i && !(cmd_valid_i ? core_bit_i : hold_q)) |=> !adc_en_o); // R8
endmodule

// File: rtl/vref_power_ctrl.sv
module vref_power_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_mode,
  input  logic             bus_stop,
  input  logic             bus_rstart,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             conv_start,
  input  logic             conv_done,
  output logic             ref_en,
  output logic             adc_en,
  output logic             ref_ready
);
  import vpc_pkg::*;

  logic boundary;
  logic turn_on;

  assign boundary = bus_stop | bus_rstart;

  vpc_ref_commit u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid),
    .ref_bit_i   (wants_ref(cmd_mode)),
    .boundary_i  (boundary),
    .ref_en_o    (ref_en),
    .turn_on_o   (turn_on)
  );

  vpc_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (turn_on),
    .load_val_i (settle_cycles),
    .run_i      (ref_en),
    .ready_o    (ref_ready)
  );

  vpc_core_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid_i  (cmd_valid),
    .core_bit_i   (wants_core(cmd_mode)),
    .conv_start_i (conv_start),
    .conv_done_i  (conv_done),
    .adc_en_o     (adc_en)
  );

  AST_READY_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready |-> ref_en); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (!ref_en && !ref_ready)); // R1
endmodule

// File: tb/vref_power_ctrl_bench.sv
module vref_power_ctrl_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_mode = 2'b00;
  logic bus_stop = 1'b0;
  logic bus_rstart = 1'b0;
  logic [CNT_W-1:0] settle_cycles = '0;
  logic conv_start = 1'b0;
  logic conv_done = 1'b0;
  logic ref_en, adc_en, ref_ready;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vref_power_ctrl #(.CNT_W(CNT_W)) u_vref_power_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .bus_stop(bus_stop), .bus_rstart(bus_rstart), .settle_cycles(settle_cycles),
    .conv_start(conv_start), .conv_done(conv_done),
    .ref_en(ref_en), .adc_en(adc_en), .ref_ready(ref_ready)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One-cycle strobe of any mix of command and boundary; returns after the edge.
  task automatic pulse(input logic cv, input logic [1:0] m, input logic st, input logic rs);
    @(negedge clk);
    cmd_valid = cv; cmd_mode = m; bus_stop = st; bus_rstart = rs;
    @(negedge clk);
    cmd_valid = 1'b0; bus_stop = 1'b0; bus_rstart = 1'b0;
  endtask

  task automatic conv(input logic s, input logic d);
    @(negedge clk);
    conv_start = s; conv_done = d;
    @(negedge clk);
    conv_start = 1'b0; conv_done = 1'b0;
  endtask

  task automatic t_reset;
    step(1);
    check("R1", "ref_en", ref_en, 1'b0);
    check("R1", "adc_en", adc_en, 1'b0);
    check("R1", "ref_ready", ref_ready, 1'b0);
  endtask

  task automatic t_deferred_on;
    settle_cycles = 3;
    pulse(1, 2'b10, 0, 0);
    check("R2", "ref_en after cmd", ref_en, 1'b0);
    step(3);
    check("R2", "ref_en idle wait", ref_en, 1'b0);
    check("R8", "adc_en mode 10 idle", adc_en, 1'b0);
    pulse(0, 2'b00, 1, 0);
    check("R2", "ref_en after stop", ref_en, 1'b1);
    check("R5", "ready at turn-on", ref_ready, 1'b0);
    step(2);
    check("R5", "ready before N", ref_ready, 1'b0);
    step(1);
    check("R5", "ready at N", ref_ready, 1'b1);
  endtask

  task automatic t_keep_on;
    pulse(1, 2'b11, 0, 0);
    check("R4", "ref_en kept", ref_en, 1'b1);
    check("R4", "ready kept", ref_ready, 1'b1);
    check("R7", "adc_en mode 11", adc_en, 1'b1);
    pulse(0, 2'b00, 0, 1);
    check("R4", "ready after rstart", ref_ready, 1'b1);
  endtask

  task automatic t_off;
    pulse(1, 2'b01, 0, 0);
    check("R3", "ref_en off", ref_en, 1'b0);
    check("R5", "ready off", ref_ready, 1'b0);
    check("R7", "adc_en mode 01", adc_en, 1'b1);
    conv(1, 0); conv(0, 1);
    check("R7", "adc_en after conv mode 01", adc_en, 1'b1);
  endtask

  task automatic t_cancel;
    pulse(1, 2'b10, 0, 0);
    pulse(1, 2'b00, 0, 0);
    pulse(0, 2'b00, 1, 0);
    check("R3", "cancelled turn-on", ref_en, 1'b0);
    check("R8", "adc_en mode 00", adc_en, 1'b0);
  endtask

  task automatic t_restart;
    settle_cycles = 5;
    pulse(1, 2'b11, 0, 0);
    pulse(0, 2'b00, 1, 0);
    check("R6", "first on", ref_en, 1'b1);
    step(2);
    pulse(1, 2'b00, 0, 0);
    check("R6", "off mid-settle", ref_en, 1'b0);
    pulse(1, 2'b10, 0, 0);
    pulse(0, 2'b00, 0, 1);
    check("R6", "on again", ref_en, 1'b1);
    step(4);
    check("R6", "ready before full interval", ref_ready, 1'b0);
    step(1);
    check("R6", "ready at full interval", ref_ready, 1'b1);
  endtask

  task automatic t_zero_settle;
    pulse(1, 2'b00, 0, 0);
    settle_cycles = 0;
    pulse(1, 2'b10, 0, 0);
    pulse(0, 2'b00, 1, 0);
    check("R5", "ref_en zero settle", ref_en, 1'b1);
    check("R5", "ready zero settle", ref_ready, 1'b1);
  endtask

  task automatic t_conv_gate;
    check("R8", "adc_en before conv", adc_en, 1'b0);
    conv(1, 0);
    check("R8", "adc_en after start", adc_en, 1'b1);
    step(2);
    check("R8", "adc_en mid conv", adc_en, 1'b1);
    @(negedge clk);
    conv_done = 1'b1;
    #1;
    check("R8", "adc_en in done cycle", adc_en, 1'b1);
    @(negedge clk);
    conv_done = 1'b0;
    check("R8", "adc_en after done", adc_en, 1'b0);
  endtask

  task automatic t_same_cycle;
    settle_cycles = 2;
    pulse(1, 2'b00, 0, 0);
    pulse(1, 2'b10, 0, 0);
    pulse(1, 2'b00, 1, 0);
    check("R9", "commit then override", ref_en, 1'b0);
    pulse(1, 2'b10, 0, 0);
    pulse(1, 2'b11, 0, 1);
    check("R9", "commit with on cmd", ref_en, 1'b1);
    pulse(1, 2'b00, 0, 0);
    pulse(1, 2'b10, 1, 0);
    check("R9", "cmd after boundary waits", ref_en, 1'b0);
    pulse(0, 2'b00, 1, 0);
    check("R9", "next boundary commits", ref_en, 1'b1);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_deferred_on();
    t_keep_on();
    t_off();
    t_cancel();
    t_restart();
    t_zero_settle();
    pulse(1, 2'b10, 0, 0);
    t_conv_gate();
    t_same_cycle();
    step(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule